// File: doc/BRIEF.md
# Zero-Cross Gated Update Controller

This controller owns the active input-gain code and the active volume code of a stereo audio path. A serial control receiver hands it a new pair of codes with a one-cycle update strobe, together with the update mode. The mode holds the zero-cross enable, the detection point, manual or automatic detection, and the overflow timeout. The mode is captured on the same strobe as the codes, so a single frame can carry both.

With zero-cross gating disabled, the new codes become active on the clock edge that samples the strobe. With gating enabled, a code that differs from the active one is held pending. It is applied only when a zero-crossing pulse arrives from an external comparator, or when the overflow timer expires.

The controller also drives a select output that chooses which analog stage feeds the comparator. In manual mode that stage is fixed by the mode. In automatic mode the select follows the stage being updated. The gain stage is served first, and then the volume stage, each with its own crossing or timeout. The timer counts milliseconds from a prescaled system clock.

Top module: `zc_update_ctrl`

## Requirements
- R1: After synchronous reset, `act_gain`, `act_vol` and `cmp_src` are all 0.
- R2: When `upd_stb` is high and `zc_en` is 0, `act_gain` and `act_vol` take `new_gain` and `new_vol` on that same clock edge, and any pending update is dropped.
- R3: When `upd_stb` is high and `zc_en` is 1, the active codes do not change on that edge. Afterwards they change only on an edge where `zc_pulse` is high or the overflow timer expires.
- R4: In manual mode (`det_auto` = 0), `cmp_src` equals the `det_sel` value captured with the last strobe, one cycle after that strobe. Value 0 selects the gain stage and 1 selects the volume stage. A single crossing or timeout applies every pending code at once.
- R5: In automatic mode (`det_auto` = 1), when both codes changed, the gain code is applied on the first crossing or timeout and the volume code on the next. The volume code never changes while the gain code is still pending.
- R6: In automatic mode, `cmp_src` is 0 while a gain update is pending. It is 1 while only a volume update is pending, and it holds its value when nothing is pending. `cmp_src` updates one cycle after the state it reflects.
- R7: The overflow timeout is BASE_MS << {tmo_sel[1], tmo_sel[0]} milliseconds. Here `tmo_sel[0]` is the first timer bit and `tmo_sel[1]` is the second, so with BASE_MS = 10 the settings 00, 01, 10 and 11 give 10, 20, 40 and 80 ms. With a millisecond of TICK_DIV cycles, a pending stage is applied exactly timeout × TICK_DIV cycles after its wait began, if no crossing arrives first.
- R8: A strobe that arrives while an update is pending replaces the pending codes and restarts the timer from zero.
- R9: A `zc_pulse` in the same cycle as `upd_stb` is ignored: it applies neither the old pending code nor the new one.
- R10: With gating enabled, a code equal to the active code is not made pending. In automatic mode, an update that changes only the volume points `cmp_src` at the volume stage at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_stb | input | 1 | One-cycle strobe: new codes and mode are valid |
| new_gain | input | GAIN_W | Requested input-gain code |
| new_vol | input | VOL_W | Requested volume code |
| zc_en | input | 1 | 1 = wait for zero crossing, 0 = apply at once |
| det_sel | input | 1 | Manual detection point: 0 gain stage, 1 volume stage |
| det_auto | input | 1 | 1 = automatic detection point, 0 = manual |
| tmo_sel | input | 2 | Timeout select, bit 0 first timer bit, bit 1 second |
| zc_pulse | input | 1 | Synchronous zero-crossing pulse from the comparator |
| act_gain | output | GAIN_W | Active input-gain code |
| act_vol | output | VOL_W | Active volume code |
| cmp_src | output | 1 | Comparator source: 0 gain stage, 1 volume stage |

## Verification
The assertions assume that `zc_pulse` is already synchronous to `clk` and that `upd_stb` is a single-cycle pulse. They also assume that the mode inputs are only meaningful in the strobe cycle. The bench drives every input on the falling edge and raises each strobe and each pulse for exactly one cycle. It leaves at least one cycle between successive events, except where R9 deliberately places a strobe and a pulse in the same cycle. A small prescaler and a small timeout base keep every timeout setting reachable, so each setting is measured to the exact cycle.

// File: rtl/zc_pkg.sv
package zc_pkg;
  // Mode captured together with the codes on each update strobe
  typedef struct packed {
    logic       det_sel;
    logic       det_auto;
    logic [1:0] tmo_sel;
  } zc_mode_t;
endpackage

// File: rtl/zc_tick_gen.sv
module zc_tick_gen #(
  parameter int unsigned TICK_DIV = 48000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] pre_q;

  assign tick = run && (pre_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr || !run) pre_q <= '0;
    else if (tick)          pre_q <= '0;
    else                    pre_q <= pre_q + 1'b1;
  end

  // R7: the prescaler never runs past its last count
  p_pre_in_range_r7: assert property (@(posedge clk) disable iff (rst)
    pre_q <= LAST);
endmodule

// File: rtl/zc_timeout.sv
module zc_timeout #(
  parameter int unsigned BASE_MS = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       tick,
  input  logic [1:0] tmo_sel,
  output logic       expire
);
  localparam int LW = $clog2(BASE_MS * 8 + 1);

  logic [LW-1:0] limit;
  logic [LW-1:0] cnt_q;

  // 00 -> base, 01 -> 2x, 10 -> 4x, 11 -> 8x
  assign limit  = LW'(BASE_MS) << tmo_sel;
  assign expire = tick && (cnt_q == limit - LW'(1));

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt_q <= '0;
    else if (expire) cnt_q <= '0;
    else if (tick)   cnt_q <= cnt_q + 1'b1;
  end

  // R7: the elapsed count stays below the selected limit
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    cnt_q < limit);
endmodule

// File: rtl/zc_src_sel.sv
module zc_src_sel (
  input  logic clk,
  input  logic rst,
  input  logic det_auto,
  input  logic det_sel,
  input  logic gain_pend,
  input  logic vol_pend,
  output logic cmp_src
);
  logic src_d;

  always_comb begin
    if (!det_auto)     src_d = det_sel;
    else if (gain_pend) src_d = 1'b0;
    else if (vol_pend)  src_d = 1'b1;
    else                src_d = cmp_src;
  end

  always_ff @(posedge clk) begin
    if (rst) cmp_src <= 1'b0;
    else     cmp_src <= src_d;
  end

  // R6: automatic mode points at the gain stage while gain waits
  p_auto_gain_first_r6: assert property (@(posedge clk) disable iff (rst)
    (det_auto && gain_pend) |=> !cmp_src);
  // R4: manual mode follows the captured detection point
  p_manual_follow_r4: assert property (@(posedge clk) disable iff (rst)
    !det_auto |=> (cmp_src == $past(det_sel)));
endmodule

// File: rtl/zc_update_ctrl.sv
module zc_update_ctrl
  import zc_pkg::*;
#(
  parameter int unsigned GAIN_W   = 5,
  parameter int unsigned VOL_W    = 7,
  parameter int unsigned TICK_DIV = 48000,
  parameter int unsigned BASE_MS  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_stb,
  input  logic [GAIN_W-1:0] new_gain,
  input  logic [VOL_W-1:0]  new_vol,
  input  logic              zc_en,
  input  logic              det_sel,
  input  logic              det_auto,
  input  logic [1:0]        tmo_sel,
  input  logic              zc_pulse,
  output logic [GAIN_W-1:0] act_gain,
  output logic [VOL_W-1:0]  act_vol,
  output logic              cmp_src
);
  zc_mode_t          mode_q;
  logic [GAIN_W-1:0] pend_gain_q;
  logic [VOL_W-1:0]  pend_vol_q;
  logic              gain_pend_q;
  logic              vol_pend_q;
  logic              any_pend;
  logic              tick;
  logic              tmo_expire;
  logic              evt;
  logic              tmr_clr;

  assign any_pend = gain_pend_q || vol_pend_q;
  // A strobe in the same cycle takes precedence over any crossing
  assign evt      = any_pend && !upd_stb && (zc_pulse || tmo_expire);
  assign tmr_clr  = upd_stb || evt || !any_pend;

  zc_tick_gen #(.TICK_DIV(TICK_DIV)) i_tick (
    .clk (clk),
    .rst (rst),
    .clr (tmr_clr),
    .run (any_pend),
    .tick(tick)
  );

  zc_timeout #(.BASE_MS(BASE_MS)) i_tmo (
    .clk    (clk),
    .rst    (rst),
    .clr    (tmr_clr),
    .tick   (tick),
    .tmo_sel(mode_q.tmo_sel),
    .expire (tmo_expire)
  );

  zc_src_sel i_src (
    .clk      (clk),
    .rst      (rst),
    .det_auto (mode_q.det_auto),
    .det_sel  (mode_q.det_sel),
    .gain_pend(gain_pend_q),
    .vol_pend (vol_pend_q),
    .cmp_src  (cmp_src)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= '0;
      pend_gain_q <= '0;
      pend_vol_q  <= '0;
      gain_pend_q <= 1'b0;
      vol_pend_q  <= 1'b0;
      act_gain    <= '0;
      act_vol     <= '0;
    end else if (upd_stb) begin
      mode_q.det_sel  <= det_sel;
      mode_q.det_auto <= det_auto;
      mode_q.tmo_sel  <= tmo_sel;
      pend_gain_q     <= new_gain;
      pend_vol_q      <= new_vol;
      if (!zc_en) begin
        act_gain    <= new_gain;
        act_vol     <= new_vol;
        gain_pend_q <= 1'b0;
        vol_pend_q  <= 1'b0;
      end else begin
        gain_pend_q <= (new_gain != act_gain);
        vol_pend_q  <= (new_vol != act_vol);
      end
    end else if (evt) begin
      if (mode_q.det_auto) begin
        if (gain_pend_q) begin
          act_gain    <= pend_gain_q;
          gain_pend_q <= 1'b0;
        end else begin
          act_vol    <= pend_vol_q;
          vol_pend_q <= 1'b0;
        end
      end else begin
        if (gain_pend_q) act_gain <= pend_gain_q;
        if (vol_pend_q)  act_vol  <= pend_vol_q;
        gain_pend_q <= 1'b0;
        vol_pend_q  <= 1'b0;
      end
    end
  end

  // R2: gating off applies the codes on the strobe edge
  p_direct_apply_r2: assert property (@(posedge clk) disable iff (rst)
    (upd_stb && !zc_en) |=> (act_gain == $past(new_gain)) && (act_vol == $past(new_vol)));
  // R3: a gated strobe leaves the active codes untouched
  p_gated_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (upd_stb && zc_en) |=> ($stable(act_gain) && $stable(act_vol)));
  // R3: without strobe, crossing or expiry nothing changes
  p_no_event_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!upd_stb && !zc_pulse && !tmo_expire) |=> ($stable(act_gain) && $stable(act_vol)));
  // R5: the volume stage waits behind a pending gain stage
  p_vol_after_gain_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_q.det_auto && gain_pend_q && !upd_stb) |=> $stable(act_vol));
  // R8: a new frame restarts the pending wait
  p_restart_r8: assert property (@(posedge clk) disable iff (rst)
    upd_stb |=> !tmo_expire);
endmodule

// File: tb/test_zc_update_ctrl.sv
module test_zc_update_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int GW  = 5;
  localparam int VW  = 7;
  localparam int DIV = 3;
  localparam int BASE = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic upd_stb = 1'b0;
  logic [GW-1:0] new_gain = '0;
  logic [VW-1:0] new_vol = '0;
  logic zc_en = 1'b0, det_sel = 1'b0, det_auto = 1'b0, zc_pulse = 1'b0;
  logic [1:0] tmo_sel = 2'b00;
  logic [GW-1:0] act_gain;
  logic [VW-1:0] act_vol;
  logic cmp_src;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zc_update_ctrl #(.GAIN_W(GW), .VOL_W(VW), .TICK_DIV(DIV), .BASE_MS(BASE)) i_zc_update_ctrl (
    .clk(clk), .rst(rst), .upd_stb(upd_stb), .new_gain(new_gain), .new_vol(new_vol),
    .zc_en(zc_en), .det_sel(det_sel), .det_auto(det_auto), .tmo_sel(tmo_sel),
    .zc_pulse(zc_pulse), .act_gain(act_gain), .act_vol(act_vol), .cmp_src(cmp_src)
  );

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic send(int g, int v, bit zc, bit ds, bit au, int ts);
    @(negedge clk);
    upd_stb = 1'b1; new_gain = GW'(g); new_vol = VW'(v);
    zc_en = zc; det_sel = ds; det_auto = au; tmo_sel = 2'(ts);
    @(negedge clk);
    upd_stb = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk); zc_pulse = 1'b1;
    @(negedge clk); zc_pulse = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_change(output int n);
    int pg, pv;
    pg = act_gain; pv = act_vol; n = 0;
    while (act_gain == pg && act_vol == pv && n < 2000) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    idle(3);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    chk("R1 gain", act_gain, 0); chk("R1 vol", act_vol, 0); chk("R1 src", cmp_src, 0);

    // R2 sweep with gating off
    for (int g = 0; g < 32; g++) begin
      send(g, (g * 37 + 5) % 128, 0, 0, 0, 0);
      chk("R2 gain", act_gain, g); chk("R2 vol", act_vol, (g * 37 + 5) % 128);
    end
    send(1, 1, 0, 0, 0, 3);

    // R3/R4 manual at volume point
    send(9, 50, 1, 1, 0, 3);
    idle(4);
    chk("R3 gain held", act_gain, 1); chk("R3 vol held", act_vol, 1);
    chk("R4 src vol", cmp_src, 1);
    pulse();
    chk("R4 gain both", act_gain, 9); chk("R4 vol both", act_vol, 50);
    // R4 manual at gain point
    send(10, 51, 1, 0, 0, 3);
    idle(2);
    chk("R4 src gain", cmp_src, 0);
    pulse();
    chk("R4 gain", act_gain, 10); chk("R4 vol", act_vol, 51);

    // R5/R6 automatic, both changed
    send(12, 60, 1, 1, 1, 3);
    idle(2);
    chk("R6 src gain", cmp_src, 0);
    chk("R5 vol waits", act_vol, 51);
    pulse();
    chk("R5 gain first", act_gain, 12); chk("R5 vol still", act_vol, 51);
    idle(1);
    chk("R6 src vol", cmp_src, 1);
    pulse();
    chk("R5 vol second", act_vol, 60);
    idle(2);
    chk("R6 src hold", cmp_src, 1);

    // R10 only volume changes, automatic: switches at once, gain stays
    send(0, 0, 0, 0, 0, 0);
    idle(2);
    chk("R10 src base", cmp_src, 0);
    send(0, 70, 1, 0, 1, 3);
    idle(1);
    chk("R10 src vol", cmp_src, 1);
    pulse();
    chk("R10 vol", act_vol, 70); chk("R10 gain", act_gain, 0);

    // R7 timeout sweep in manual mode
    for (int ts = 0; ts < 4; ts++) begin
      send(ts + 20, ts + 80, 1, 0, 0, ts);
      wait_change(n);
      chk("R7 timeout cycles", n, (BASE << ts) * DIV);
      chk("R7 gain", act_gain, ts + 20); chk("R7 vol", act_vol, ts + 80);
    end

    // R7/R5 automatic timeout restarts for second stage
    send(3, 90, 1, 0, 1, 1);
    wait_change(n);
    chk("R7 auto gain cycles", n, (BASE << 1) * DIV);
    chk("R5 auto gain", act_gain, 3); chk("R5 auto vol", act_vol, 83);
    wait_change(n);
    chk("R7 auto vol cycles", n, (BASE << 1) * DIV);
    chk("R5 auto vol", act_vol, 90);

    // R8 replace pending and restart timer
    send(5, 5, 1, 0, 0, 0);
    idle(3);
    send(6, 7, 1, 0, 0, 0);
    wait_change(n);
    chk("R8 restart cycles", n, BASE * DIV);
    chk("R8 gain", act_gain, 6); chk("R8 vol", act_vol, 7);

    // R9 strobe and pulse in the same cycle
    send(11, 11, 1, 0, 0, 3);
    @(negedge clk);
    upd_stb = 1'b1; zc_pulse = 1'b1; new_gain = GW'(13); new_vol = VW'(14);
    zc_en = 1'b1; det_sel = 1'b0; det_auto = 1'b0; tmo_sel = 2'b11;
    @(negedge clk);
    upd_stb = 1'b0; zc_pulse = 1'b0;
    chk("R9 gain ignored", act_gain, 6); chk("R9 vol ignored", act_vol, 7);
    pulse();
    chk("R9 gain new", act_gain, 13); chk("R9 vol new", act_vol, 14);

    // R10 unchanged codes wait for nothing
    send(13, 14, 1, 1, 0, 0);
    idle(BASE * DIV + 4);
    chk("R10 gain same", act_gain, 13); chk("R10 vol same", act_vol, 14);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule